// File: doc/BRIEF.md
# Signed Multiply-High Execution Unit

This unit decodes and executes one instruction: a signed 32×32 multiply that returns only the upper word of the 64-bit product. It takes an instruction word, a selector that says which of two encoding layouts the word uses, the two source register values (already read by the surrounding core) and the result of the condition check. It returns the destination register index, a write enable, the 32-bit result and two error flags. One flag marks an unpredictable use of register 15. The other marks a word that matches neither layout.

The product is formed at full 64-bit signed width. A rounding bit in the instruction optionally adds 2^31 to the product before the upper word is taken. This gives round-to-nearest instead of truncation. The unit is a two-stage pipeline with valid/ready handshakes at both ends. The first stage decodes and multiplies. The second stage rounds and selects the upper word. A result is accepted every cycle while the consumer is ready. Nothing is lost while the consumer stalls.

Top module: `smh_unit`

## Requirements
- R1: Both operands are signed 32-bit two's-complement values. With the rounding bit clear, `out_data` is bits 63:32 of their full 64-bit signed product.
- R2: With the rounding bit set, 0x80000000 is added to the 64-bit product modulo 2^64, and `out_data` is bits 63:32 of that sum.
- R3: Word layout (`two_half`=0): bits 31:28 must not be 1111, bits 27:20 = 01110101, bits 15:12 = 1111, bits 7:6 = 00 and bit 4 = 1. The destination is bits 19:16, the second source is bits 11:8, the rounding bit is bit 5 and the first source is bits 3:0.
- R4: Halfword-pair layout (`two_half`=1): the leading halfword sits in `insn[31:16]` and the trailing halfword in `insn[15:0]`. The leading halfword has bits 15:4 = 111110110101, with the first source in bits 3:0. The trailing halfword has bits 15:12 = 1111, bits 7:5 = 000, the destination in bits 11:8, the rounding bit in bit 4 and the second source in bits 3:0.
- R5: If the destination or either source index is 15, `out_unpred`=1, `out_we`=0 and `out_data`=0, whatever `cond_ok` is. `out_rd` still shows the decoded destination.
- R6: With `cond_ok`=0, a well-formed instruction gives `out_we`=0 and `out_data`=0, with the decoded `out_rd` and both error flags clear.
- R7: A word that matches neither pattern of its selected layout gives `out_undef`=1, `out_unpred`=0, `out_we`=0, `out_rd`=0 and `out_data`=0.
- R8: An operation accepted at clock edge k appears on the outputs after edge k+1 when the output is not stalled. `in_ready` stays high, so one operation is accepted every cycle. `in_ready` is low only while both stages are full and `out_ready` is low.
- R9: While `out_valid`=1 and `out_ready`=0, every output holds its value. Results leave in acceptance order, and none is lost or duplicated.
- R10: During and after synchronous active-high reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| insn | input | 32 | Instruction word |
| two_half | input | 1 | 1 = halfword-pair layout, 0 = word layout |
| op_a | input | 32 | Value of the first source register |
| op_b | input | 32 | Value of the second source register |
| cond_ok | input | 1 | Condition check passed |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_rd | output | 4 | Destination register index |
| out_we | output | 1 | Register write enable |
| out_data | output | 32 | Upper word of the (rounded) product |
| out_unpred | output | 1 | Register 15 used |
| out_undef | output | 1 | Word matches neither pattern |

## Verification
The assertions check these properties on every cycle:
- an output held under stall stays stable;
- a write never comes with either error flag or with index 15;
- an undefined result carries neither a write nor data;
- a non-writing result carries zero data;
- back-pressure reaches `in_ready` only through a stalled, full pipe.

Some properties can only be shown by the bench's scenarios against its own 64-bit reference:
- the arithmetic, including rounding wraparound at the extreme operand corners;
- the field positions of both layouts;
- the exact two-cycle latency;
- in-order, lossless delivery under random back-pressure.

// File: rtl/smh_pkg.sv
package smh_pkg;
    localparam int XLEN    = 32;
    localparam int RIDX_W  = 4;
    localparam int PROD_W  = 2 * XLEN;

    localparam logic [RIDX_W-1:0] PC_IDX    = '1;
    localparam logic [3:0]        COND_NV   = 4'hF;
    localparam logic [7:0]        WORD_OPC  = 8'h75;
    localparam logic [11:0]       PAIR_OPC  = 12'hFB5;
    localparam logic [PROD_W-1:0] RND_CONST = PROD_W'(1) << (XLEN - 1);

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;
    typedef logic [PROD_W-1:0] prod_t;

    typedef enum logic [1:0] {
        DEC_OK     = 2'd0,
        DEC_UNPRED = 2'd1,
        DEC_UNDEF  = 2'd2
    } dec_kind_e;

    typedef struct packed {
        dec_kind_e kind;
        ridx_t     rd;
        logic      rnd;
    } dec_t;

    typedef struct packed {
        ridx_t rd;
        logic  we;
        logic  unpred;
        logic  undef;
        logic  rnd;
        prod_t prod;
    } mul_stage_t;

    typedef struct packed {
        ridx_t rd;
        logic  we;
        logic  unpred;
        logic  undef;
        word_t data;
    } res_t;

    function automatic logic any_pc(ridx_t a, ridx_t b, ridx_t c);
        return (a == PC_IDX) || (b == PC_IDX) || (c == PC_IDX);
    endfunction
endpackage

// File: rtl/smh_decode.sv
module smh_decode
    import smh_pkg::*;
(
    input  word_t insn,
    input  logic  two_half,
    output dec_t  dec
);
    logic [15:0] hw_lead;
    logic [15:0] hw_trail;
    logic        word_hit;
    logic        pair_hit;
    ridx_t       w_rd, w_rn, w_rm;
    ridx_t       p_rd, p_rn, p_rm;
    ridx_t       sel_rd, sel_rn, sel_rm;
    logic        sel_hit, sel_rnd;

    assign hw_lead  = insn[31:16];
    assign hw_trail = insn[15:0];

    // word layout
    assign word_hit = (insn[31:28] != COND_NV) && (insn[27:20] == WORD_OPC) &&
                      (insn[15:12] == 4'hF) && (insn[7:6] == 2'b00) && insn[4];
    assign w_rd = insn[19:16];
    assign w_rm = insn[11:8];
    assign w_rn = insn[3:0];

    // halfword-pair layout
    assign pair_hit = (hw_lead[15:4] == PAIR_OPC) && (hw_trail[15:12] == 4'hF) &&
                      (hw_trail[7:5] == 3'b000);
    assign p_rn = hw_lead[3:0];
    assign p_rd = hw_trail[11:8];
    assign p_rm = hw_trail[3:0];

    always_comb begin
        if (two_half) begin
            sel_hit = pair_hit;
            sel_rd  = p_rd;
            sel_rn  = p_rn;
            sel_rm  = p_rm;
            sel_rnd = hw_trail[4];
        end else begin
            sel_hit = word_hit;
            sel_rd  = w_rd;
            sel_rn  = w_rn;
            sel_rm  = w_rm;
            sel_rnd = insn[5];
        end
    end

    always_comb begin
        dec.rnd = sel_rnd;
        dec.rd  = sel_rd;
        if (!sel_hit) begin
            dec.kind = DEC_UNDEF;
            dec.rd   = '0;
            dec.rnd  = 1'b0;
        end else if (any_pc(sel_rd, sel_rn, sel_rm)) begin
            dec.kind = DEC_UNPRED;
        end else begin
            dec.kind = DEC_OK;
        end
    end
endmodule

// File: rtl/smh_mul.sv
module smh_mul
    import smh_pkg::*;
(
    input  word_t a,
    input  word_t b,
    output prod_t prod
);
    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] b_ext;

    assign a_ext = $signed({{XLEN{a[XLEN-1]}}, a});
    assign b_ext = $signed({{XLEN{b[XLEN-1]}}, b});
    assign prod  = prod_t'(a_ext * b_ext);
endmodule

// File: rtl/smh_round.sv
module smh_round
    import smh_pkg::*;
(
    input  prod_t prod,
    input  logic  rnd,
    output word_t hi
);
    prod_t addend;

    assign addend = rnd ? RND_CONST : '0;
    // wraps modulo 2^64, then keeps the upper word
    assign hi = word_t'((prod + addend) >> XLEN);
endmodule

// File: rtl/smh_pipe_reg.sv
module smh_pipe_reg #(
    parameter type T = logic
) (
    input  logic clk,
    input  logic rst,
    input  logic up_valid,
    output logic up_ready,
    input  T     up_data,
    output logic dn_valid,
    input  logic dn_ready,
    output T     dn_data
);
    logic held;
    T     store;

    assign up_ready = !held || dn_ready;
    assign dn_valid = held;
    assign dn_data  = store;

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= 1'b0;
            store <= '0;
        end else if (up_ready) begin
            held <= up_valid;
            if (up_valid) store <= up_data;
        end
    end
endmodule

// File: rtl/smh_unit.sv
module smh_unit
    import smh_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] insn,
    input  logic        two_half,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic        cond_ok,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [3:0]  out_rd,
    output logic        out_we,
    output logic [31:0] out_data,
    output logic        out_unpred,
    output logic        out_undef
);
    dec_t       dec;
    prod_t      prod;
    mul_stage_t s1_in, s1_q;
    logic       s1_valid, s1_ready;
    word_t      hi;
    res_t       s2_in, s2_q;

    smh_decode u_decode (
        .insn     (insn),
        .two_half (two_half),
        .dec      (dec)
    );

    smh_mul u_mul (
        .a    (op_a),
        .b    (op_b),
        .prod (prod)
    );

    always_comb begin
        s1_in.rd     = dec.rd;
        s1_in.we     = cond_ok && (dec.kind == DEC_OK);
        s1_in.unpred = (dec.kind == DEC_UNPRED);
        s1_in.undef  = (dec.kind == DEC_UNDEF);
        s1_in.rnd    = dec.rnd;
        s1_in.prod   = prod;
    end

    smh_pipe_reg #(.T(mul_stage_t)) u_stage1 (
        .clk      (clk),
        .rst      (rst),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  (s1_in),
        .dn_valid (s1_valid),
        .dn_ready (s1_ready),
        .dn_data  (s1_q)
    );

    smh_round u_round (
        .prod (s1_q.prod),
        .rnd  (s1_q.rnd),
        .hi   (hi)
    );

    always_comb begin
        s2_in.rd     = s1_q.rd;
        s2_in.we     = s1_q.we;
        s2_in.unpred = s1_q.unpred;
        s2_in.undef  = s1_q.undef;
        s2_in.data   = s1_q.we ? hi : '0;
    end

    smh_pipe_reg #(.T(res_t)) u_stage2 (
        .clk      (clk),
        .rst      (rst),
        .up_valid (s1_valid),
        .up_ready (s1_ready),
        .up_data  (s2_in),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (s2_q)
    );

    assign out_rd     = s2_q.rd;
    assign out_we     = s2_q.we;
    assign out_data   = s2_q.data;
    assign out_unpred = s2_q.unpred;
    assign out_undef  = s2_q.undef;
endmodule

// File: rtl/smh_unit_chk.sv
module smh_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [3:0]  out_rd,
    input logic        out_we,
    input logic [31:0] out_data,
    input logic        out_unpred,
    input logic        out_undef
);
    // R10: pipe is empty after a reset cycle
    p_reset_empty_r10: assert property (@(posedge clk) rst |=> !out_valid);

    // R9: stalled output holds
    p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_rd) &&
        $stable(out_we) && $stable(out_unpred) && $stable(out_undef));

    // R5: a write never carries an error flag or index 15
    p_write_clean_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_we |-> !out_unpred && !out_undef && out_rd != 4'hF);

    // R7: undefined result is inert
    p_undef_inert_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_undef |-> !out_unpred && !out_we && out_data == 32'h0 && out_rd == 4'h0);

    // R6: no write means zero data
    p_nowrite_zero_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_we |-> out_data == 32'h0);

    // R8: back-pressure only from a stalled, full pipe
    p_ready_flow_r8: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid && !out_ready);

    // R8: offers while blocked are not silently consumed
    p_offer_seen_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_ready |=> out_valid);
endmodule

bind smh_unit smh_unit_chk u_chk (.*);

// File: tb/smh_unit_bench.sv
`timescale 1ns/1ps
module smh_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] insn = '0;
    logic        two_half = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        cond_ok = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [3:0]  out_rd;
    logic        out_we;
    logic [31:0] out_data;
    logic        out_unpred;
    logic        out_undef;

    smh_unit u_smh_unit (.*);

    always #2 clk = ~clk;

    typedef struct packed {
        logic [3:0]  rd;
        logic        we;
        logic        unpred;
        logic        undef;
        logic [31:0] data;
    } exp_t;

    exp_t        q_exp[$];
    string       q_tag[$];
    int unsigned q_acc[$];
    bit          q_lat[$];

    int          checks = 0;
    int          fails = 0;
    int unsigned cyc = 0;
    bit          stall_en = 1'b0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #1;
        out_ready = stall_en ? ($urandom_range(2) != 0) : 1'b1;
    end

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_hi(logic [31:0] a, logic [31:0] b, bit r);
        logic signed [63:0] p;
        p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        if (r) p = p + 64'sh0000_0000_8000_0000;
        return p[63:32];
    endfunction

    function automatic logic [31:0] enc_word(logic [3:0] c, logic [3:0] rd, logic [3:0] rn,
                                             logic [3:0] rm, bit r);
        return {c, 8'h75, rd, 4'hF, rm, 2'b00, r, 1'b1, rn};
    endfunction

    function automatic logic [31:0] enc_pair(logic [3:0] rd, logic [3:0] rn, logic [3:0] rm, bit r);
        return {12'hFB5, rn, 4'hF, rd, 3'b000, r, rm};
    endfunction

    task automatic push(logic [31:0] w, bit th, logic [31:0] a, logic [31:0] b, bit c,
                        exp_t e, string tag);
        bit acc;
        bit first;
        first = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; insn = w; two_half = th; op_a = a; op_b = b; cond_ok = c;
        forever begin
            #0.5;
            acc = in_ready;
            @(posedge clk);
            if (acc) break;
            first = 1'b0;
            @(negedge clk);
        end
        #0.5;
        in_valid = 1'b0;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        q_acc.push_back(cyc);
        q_lat.push_back(!stall_en);
        if (!stall_en) chk(first, "R8", "accepted on first offer", 64'(first), 64'd1);
    endtask

    task automatic op_good(bit th, logic [3:0] rd, logic [3:0] rn, logic [3:0] rm, bit r,
                           logic [31:0] a, logic [31:0] b, bit c, string tag);
        exp_t e;
        logic [31:0] w;
        w = th ? enc_pair(rd, rn, rm, r) : enc_word(4'($urandom_range(14)), rd, rn, rm, r);
        e.rd = rd; e.we = c; e.unpred = 1'b0; e.undef = 1'b0;
        e.data = c ? ref_hi(a, b, r) : 32'h0;
        push(w, th, a, b, c, e, tag);
    endtask

    task automatic op_unpred(bit th, logic [3:0] rd, logic [3:0] rn, logic [3:0] rm, bit c);
        exp_t e;
        logic [31:0] w;
        w = th ? enc_pair(rd, rn, rm, 1'b0) : enc_word(4'h3, rd, rn, rm, 1'b1);
        e.rd = rd; e.we = 1'b0; e.unpred = 1'b1; e.undef = 1'b0; e.data = 32'h0;
        push(w, th, 32'h1234_5678, 32'h7654_3210, c, e, "R5");
    endtask

    task automatic op_undef(logic [31:0] w, bit th);
        exp_t e;
        e.rd = 4'h0; e.we = 1'b0; e.unpred = 1'b0; e.undef = 1'b1; e.data = 32'h0;
        push(w, th, 32'hFFFF_FFFF, 32'h0000_0002, 1'b1, e, "R7");
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && q_exp.size() != 0; i++) @(negedge clk);
        chk(q_exp.size() == 0, "R9", "all results delivered", 64'(q_exp.size()), 64'd0);
    endtask

    // monitor / scoreboard
    bit          hold_prev = 1'b0;
    exp_t        held;
    always @(negedge clk) begin
        if (!rst) begin
            exp_t got;
            got = {out_rd, out_we, out_unpred, out_undef, out_data};
            if (hold_prev)
                chk(out_valid && got == held, "R9", "output held under stall", 64'(got), 64'(held));
            hold_prev = out_valid && !out_ready;
            held = got;
            if (out_valid && out_ready) begin
                if (q_exp.size() == 0) begin
                    chk(1'b0, "R9", "unexpected result", 64'(got), 64'd0);
                end else begin
                    exp_t e;
                    string t;
                    int unsigned a;
                    bit l;
                    e = q_exp.pop_front(); t = q_tag.pop_front();
                    a = q_acc.pop_front(); l = q_lat.pop_front();
                    chk(got == e, t, "result fields", 64'(got), 64'(e));
                    if (l) chk(cyc == a + 1, "R8", "two-cycle latency", 64'(cyc), 64'(a + 1));
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R8", "watchdog expired", 64'(cyc), 64'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    logic [31:0] corner_a [5] = '{32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h7FFF_FFFF};
    logic [31:0] corner_b [5] = '{32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 32'h9ABC_DEF0, 32'h8000_0000};

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!out_valid, "R10", "out_valid during reset", 64'(out_valid), 64'd0);
        chk(in_ready, "R10", "in_ready during reset", 64'(in_ready), 64'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R10", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready, "R10", "in_ready after reset", 64'(in_ready), 64'd1);

        // corner operands, both layouts, both rounding modes (R1, R2, R3, R4)
        for (int th = 0; th < 2; th++)
            for (int r = 0; r < 2; r++)
                for (int k = 0; k < 5; k++)
                    op_good(th[0], 4'(k + 1), 4'(k + 3), 4'(14 - k), r[0], corner_a[k], corner_b[k], 1'b1,
                            r ? (th ? "R2 R4" : "R2 R3") : (th ? "R1 R4" : "R1 R3"));

        // random operands and fields
        for (int i = 0; i < 60; i++) begin
            bit th;
            bit r;
            th = i[0]; r = i[1];
            op_good(th, 4'($urandom_range(14)), 4'($urandom_range(14)), 4'($urandom_range(14)), r,
                    $urandom, $urandom, 1'b1, r ? "R2 random" : "R1 random");
        end

        // condition failed (R6)
        op_good(1'b0, 4'd2, 4'd3, 4'd4, 1'b1, 32'h4000_0000, 32'h4000_0000, 1'b0, "R6");
        op_good(1'b1, 4'd9, 4'd1, 4'd0, 1'b0, 32'hFFFF_0000, 32'h0001_0000, 1'b0, "R6");

        // register 15 in each position (R5)
        for (int th = 0; th < 2; th++) begin
            op_unpred(th[0], 4'hF, 4'd1, 4'd2, 1'b1);
            op_unpred(th[0], 4'd5, 4'hF, 4'd2, 1'b1);
            op_unpred(th[0], 4'd5, 4'd1, 4'hF, 1'b0);
        end

        // malformed words (R7)
        op_undef(enc_word(4'hF, 4'd1, 4'd2, 4'd3, 1'b0), 1'b0);
        op_undef(enc_word(4'hE, 4'd1, 4'd2, 4'd3, 1'b0) ^ 32'h10, 1'b0);
        op_undef(enc_word(4'hE, 4'd1, 4'd2, 4'd3, 1'b0) ^ 32'h40, 1'b0);
        op_undef(enc_pair(4'd1, 4'd2, 4'd3, 1'b1), 1'b0);
        op_undef(enc_word(4'hE, 4'd1, 4'd2, 4'd3, 1'b0), 1'b1);
        op_undef(enc_pair(4'd1, 4'd2, 4'd3, 1'b0) ^ 32'h20, 1'b1);
        op_undef(enc_pair(4'd1, 4'd2, 4'd3, 1'b0) ^ 32'h1000, 1'b1);
        drain();

        // random back-pressure (R9)
        stall_en = 1'b1;
        for (int i = 0; i < 80; i++)
            op_good(i[0], 4'($urandom_range(14)), 4'($urandom_range(14)), 4'($urandom_range(14)), i[1],
                    $urandom, $urandom, 1'b1, "R9 stalled");
        drain();
        stall_en = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule